// File: doc/BRIEF.md
# Burst CRC Check and Retry Controller

This block sits on the receiving side of a fast memory link and guards each 64-bit data burst with an 8-bit CRC. The CRC does not travel on the data lanes. It arrives on a four-lane sideband, so each burst needs two sideband beats. The block holds the burst until both the data and the whole CRC have arrived. It then computes its own CRC over the data and compares the two values.

A burst whose CRC matches goes downstream unchanged. A burst whose CRC does not match is dropped. The block never tries to repair it. Instead it raises a link-retrain request and holds it until the link reports that retraining is done. Only then does it pulse a retransmit request for the same burst. The retrain reinitialises the link at the same clock rate, and the block places no limit on how many times a burst is retried.

Read and write bursts are handled the same way. A direction tag travels with each burst. Two saturating counters record CRC failures and retransmit requests. An enable input switches checking off, and with checking off every burst is released as received.

Top module: `burst_crc_guard`

## Requirements
- R1: During and after synchronous reset, out_valid, rexmit_req and retrain_req are low, both counters read zero, and dat_ready and edc_ready are high.
- R2: The CRC uses generator 0x07 (x^8+x^2+x+1) with a zero start value and no final inversion. Data is fed from dat_word bit 63 down to bit 0. The first sideband beat carries CRC bits 7:4 and the second carries bits 3:0. When checking is enabled and the CRCs match, out_valid pulses high for one cycle with out_data equal to the received word.
- R3: A burst is judged only when its data word and both sideband beats have been accepted. Once a word is held, dat_ready stays low until the burst is judged. edc_ready goes low after two beats. Neither out_valid nor retrain_req is raised before the second beat.
- R4: On a mismatch with checking enabled, the burst is not released, err_cnt increases by one, and retrain_req goes high and stays high until retrain_done is sampled high.
- R5: rexmit_req is never raised while retrain_req is high. It pulses for exactly one cycle, in the cycle after retrain_done is accepted, and in that same cycle retrain_req is low and retry_cnt has increased by one.
- R6: Every burst with one or two flipped data bits, or with any corrupted CRC value and correct data, is rejected when checking is enabled.
- R7: Retries have no limit. The same corrupted burst can be rejected any number of times in a row, and a clean copy is still released afterwards.
- R8: With chk_en low, every burst is released as received whatever its CRC. Counters stay unchanged and retrain_req stays low.
- R9: Both counters saturate at their all-ones value instead of wrapping. A high cnt_clr clears both counters on the next clock edge.
- R10: The direction tag dat_is_wr given with the data word is returned on out_is_wr with the released burst. Read and write bursts are checked the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_en | input | 1 | High enables CRC checking; low passes bursts unchecked |
| dat_valid | input | 1 | Data word offered |
| dat_ready | output | 1 | Block can accept a data word |
| dat_word | input | 64 | Burst data |
| dat_is_wr | input | 1 | Direction tag of the burst (1 = write, 0 = read) |
| edc_valid | input | 1 | Sideband CRC beat offered |
| edc_ready | output | 1 | Block can accept a sideband beat |
| edc_nib | input | 4 | Sideband beat: CRC bits 7:4 first, then 3:0 |
| out_valid | output | 1 | One-cycle pulse: a clean burst is released |
| out_data | output | 64 | Released burst data |
| out_is_wr | output | 1 | Direction tag of the released burst |
| rexmit_req | output | 1 | One-cycle request to resend the rejected burst |
| retrain_req | output | 1 | Link retrain request, held until retrain_done |
| retrain_done | input | 1 | Link reports retraining finished |
| cnt_clr | input | 1 | Synchronous clear of both counters |
| err_cnt | output | CNT_W | Saturating count of CRC mismatches |
| retry_cnt | output | CNT_W | Saturating count of retransmit requests |

## Verification
The bench builds the block with CNT_W set to 4, so both counters saturate at 15 after a few hundred cycles of forced failures. That brings the no-wrap behaviour and the clear into reach, which the 16-bit default would not. The data and CRC widths are fixed by the link format, so they keep their default sizes. The bench computes its expected CRC by polynomial long division over the 72-bit shifted message. It then sweeps every single-bit flip and a ring of adjacent double-bit flips through the full reject, retrain and resend cycle.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    localparam int BURST_W   = 64;
    localparam int CRC_W     = 8;
    localparam int EDC_LANES = 4;
    localparam int EDC_BEATS = CRC_W / EDC_LANES;
    localparam int BEAT_CW   = $clog2(EDC_BEATS + 1);
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

    typedef enum logic {
        ST_COLLECT,
        ST_RETRAIN
    } bcg_state_e;

    typedef struct packed {
        logic [BURST_W-1:0] data;
        logic               is_wr;
    } burst_t;

    // Serial CRC, most significant data bit first, zero start value.
    function automatic logic [CRC_W-1:0] crc_of(input logic [BURST_W-1:0] d);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = '0;
        for (int i = BURST_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ d[i];
            c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return c;
    endfunction

endpackage

// File: rtl/bcg_crc_cmp.sv
module bcg_crc_cmp
    import bcg_pkg::*;
(
    input  logic [BURST_W-1:0] data,
    input  logic [CRC_W-1:0]   rx_crc,
    output logic               match
);

    logic [CRC_W-1:0] local_crc;

    always_comb begin
        local_crc = crc_of(data);
        match     = (local_crc == rx_crc);
    end

endmodule

// File: rtl/bcg_capture.sv
module bcg_capture
    import bcg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               accept,
    input  logic               flush,
    input  logic               dat_valid,
    input  logic [BURST_W-1:0] dat_word,
    input  logic               dat_is_wr,
    input  logic               edc_valid,
    input  logic [EDC_LANES-1:0] edc_nib,
    output logic               dat_ready,
    output logic               edc_ready,
    output logic               full,
    output burst_t             cap,
    output logic [CRC_W-1:0]   rx_crc
);

    logic               have_data;
    logic [BEAT_CW-1:0] beat_cnt;
    logic               crc_done;

    always_comb begin
        crc_done  = (beat_cnt == BEAT_CW'(EDC_BEATS));
        dat_ready = accept && !have_data;
        edc_ready = accept && !crc_done;
        full      = have_data && crc_done;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            have_data <= 1'b0;
            beat_cnt  <= '0;
            cap       <= '0;
            rx_crc    <= '0;
        end else if (flush) begin
            have_data <= 1'b0;
            beat_cnt  <= '0;
        end else begin
            if (dat_valid && dat_ready) begin
                have_data <= 1'b1;
                cap.data  <= dat_word;
                cap.is_wr <= dat_is_wr;
            end
            if (edc_valid && edc_ready) begin
                beat_cnt <= beat_cnt + 1'b1;
                rx_crc   <= {rx_crc[CRC_W-EDC_LANES-1:0], edc_nib};
            end
        end
    end

    // R3
    data_held_chk: assert property (@(posedge clk) disable iff (rst)
        (dat_valid && dat_ready) |=> !dat_ready);

endmodule

// File: rtl/bcg_retry_fsm.sv
module bcg_retry_fsm
    import bcg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic full,
    input  logic match,
    input  logic chk_en,
    input  logic retrain_done,
    output logic accept,
    output logic flush,
    output logic release_now,
    output logic err_inc,
    output logic retry_inc,
    output logic retrain_req,
    output logic rexmit_req
);

    bcg_state_e state;
    logic       reject;

    always_comb begin
        accept      = (state == ST_COLLECT);
        release_now = accept && full && (!chk_en || match);
        reject      = accept && full && chk_en && !match;
        flush       = release_now || reject;
        err_inc     = reject;
        retry_inc   = (state == ST_RETRAIN) && retrain_done;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_COLLECT;
            retrain_req <= 1'b0;
            rexmit_req  <= 1'b0;
        end else begin
            rexmit_req <= retry_inc;
            if (reject) begin
                state       <= ST_RETRAIN;
                retrain_req <= 1'b1;
            end else if (retry_inc) begin
                state       <= ST_COLLECT;
                retrain_req <= 1'b0;
            end
        end
    end

    // R4
    retrain_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (retrain_req && !retrain_done) |=> retrain_req);

    // R5
    rexmit_after_retrain_chk: assert property (@(posedge clk) disable iff (rst)
        rexmit_req |-> (!retrain_req && $past(retrain_req)));

    // R5
    rexmit_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rexmit_req |=> !rexmit_req);

endmodule

// File: rtl/bcg_sat_cnt.sv
module bcg_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc && cnt != TOP)
            cnt <= cnt + 1'b1;
    end

    // R9
    clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (cnt >= $past(cnt)));

endmodule

// File: rtl/burst_crc_guard.sv
module burst_crc_guard
    import bcg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               chk_en,
    input  logic               dat_valid,
    output logic               dat_ready,
    input  logic [BURST_W-1:0] dat_word,
    input  logic               dat_is_wr,
    input  logic               edc_valid,
    output logic               edc_ready,
    input  logic [EDC_LANES-1:0] edc_nib,
    output logic               out_valid,
    output logic [BURST_W-1:0] out_data,
    output logic               out_is_wr,
    output logic               rexmit_req,
    output logic               retrain_req,
    input  logic               retrain_done,
    input  logic               cnt_clr,
    output logic [CNT_W-1:0]   err_cnt,
    output logic [CNT_W-1:0]   retry_cnt
);

    localparam int N_EV = 2;

    burst_t           cap;
    logic [CRC_W-1:0] rx_crc;
    logic             full, match, accept, flush, release_now;
    logic             err_inc, retry_inc;
    logic [N_EV-1:0]  ev_inc;
    logic [CNT_W-1:0] ev_cnt [N_EV];

    bcg_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .flush     (flush),
        .dat_valid (dat_valid),
        .dat_word  (dat_word),
        .dat_is_wr (dat_is_wr),
        .edc_valid (edc_valid),
        .edc_nib   (edc_nib),
        .dat_ready (dat_ready),
        .edc_ready (edc_ready),
        .full      (full),
        .cap       (cap),
        .rx_crc    (rx_crc)
    );

    bcg_crc_cmp u_cmp (
        .data   (cap.data),
        .rx_crc (rx_crc),
        .match  (match)
    );

    bcg_retry_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .full         (full),
        .match        (match),
        .chk_en       (chk_en),
        .retrain_done (retrain_done),
        .accept       (accept),
        .flush        (flush),
        .release_now  (release_now),
        .err_inc      (err_inc),
        .retry_inc    (retry_inc),
        .retrain_req  (retrain_req),
        .rexmit_req   (rexmit_req)
    );

    assign ev_inc = {retry_inc, err_inc};

    for (genvar g = 0; g < N_EV; g++) begin : g_evcnt
        bcg_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk (clk),
            .rst (rst),
            .clr (cnt_clr),
            .inc (ev_inc[g]),
            .cnt (ev_cnt[g])
        );
    end

    assign err_cnt   = ev_cnt[0];
    assign retry_cnt = ev_cnt[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_is_wr <= 1'b0;
        end else begin
            out_valid <= release_now;
            if (release_now) begin
                out_data  <= cap.data;
                out_is_wr <= cap.is_wr;
            end
        end
    end

    // R2
    release_not_in_retrain_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !retrain_req);

    // R2
    release_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

endmodule

// File: tb/burst_crc_guard_test.sv
`timescale 1ns/1ps
module burst_crc_guard_test;

    localparam int TB_CNT_W = 4;
    localparam int CNT_MAX  = (1 << TB_CNT_W) - 1;
    localparam int NV       = 8;

    // {data, data flip mask, crc flip mask, is_wr, chk_en}
    localparam logic [137:0] VEC [NV] = '{
        {64'h0000_0000_0000_0000, 64'h0, 8'h00, 1'b0, 1'b1},
        {64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 8'h00, 1'b1, 1'b1},
        {64'h0123_4567_89AB_CDEF, 64'h8000_0000_0000_0000, 8'h00, 1'b0, 1'b1},
        {64'hDEAD_BEEF_CAFE_F00D, 64'h0, 8'h10, 1'b1, 1'b1},
        {64'h5A5A_A5A5_3C3C_C3C3, 64'h0000_0001_0000_0100, 8'h00, 1'b0, 1'b1},
        {64'h1357_9BDF_2468_ACE0, 64'h0, 8'hFF, 1'b1, 1'b0},
        {64'h8000_0000_0000_0001, 64'h0, 8'h01, 1'b0, 1'b1},
        {64'h7777_0000_EEEE_1111, 64'h0040_0000_0000_0000, 8'h00, 1'b1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst, chk_en, dat_valid, dat_is_wr, edc_valid, retrain_done, cnt_clr;
    logic [63:0] dat_word;
    logic [3:0]  edc_nib;
    logic dat_ready, edc_ready, out_valid, out_is_wr, rexmit_req, retrain_req;
    logic [63:0] out_data;
    logic [TB_CNT_W-1:0] err_cnt, retry_cnt;

    int n_chk = 0;
    int n_fail = 0;
    int m_err = 0;
    int m_retry = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    burst_crc_guard #(.CNT_W(TB_CNT_W)) uut (
        .clk(clk), .rst(rst), .chk_en(chk_en),
        .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_word(dat_word),
        .dat_is_wr(dat_is_wr), .edc_valid(edc_valid), .edc_ready(edc_ready),
        .edc_nib(edc_nib), .out_valid(out_valid), .out_data(out_data),
        .out_is_wr(out_is_wr), .rexmit_req(rexmit_req), .retrain_req(retrain_req),
        .retrain_done(retrain_done), .cnt_clr(cnt_clr),
        .err_cnt(err_cnt), .retry_cnt(retry_cnt)
    );

    // Reference CRC: remainder of d * x^8 divided by x^8+x^2+x+1.
    function automatic logic [7:0] ref_crc(input logic [63:0] d);
        logic [71:0] r;
        r = {d, 8'h00};
        for (int i = 71; i >= 8; i--)
            if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h107;
        return r[7:0];
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    task automatic bump(inout int v);
        if (v < CNT_MAX) v++;
    endtask

    task automatic push_data(input logic [63:0] d, input logic wr);
        dat_word = d; dat_is_wr = wr; dat_valid = 1'b1;
        while (!dat_ready) @(negedge clk);
        @(negedge clk);
        dat_valid = 1'b0;
    endtask

    task automatic push_beat(input logic [3:0] n);
        edc_nib = n; edc_valid = 1'b1;
        while (!edc_ready) @(negedge clk);
        @(negedge clk);
        edc_valid = 1'b0;
    endtask

    task automatic push_burst(input logic [63:0] d, input logic [7:0] c, input logic wr);
        push_data(d, wr);
        push_beat(c[7:4]);
        push_beat(c[3:0]);
    endtask

    task automatic wait_outcome(output bit got_out, output bit got_rt);
        got_out = 0; got_rt = 0;
        for (int n = 0; n < 8; n++) begin
            @(negedge clk);
            if (out_valid || retrain_req) begin
                got_out = out_valid; got_rt = retrain_req;
                break;
            end
        end
    endtask

    task automatic expect_clean(input logic [63:0] d, input logic wr, input string req);
        bit go, gr;
        wait_outcome(go, gr);
        check(go && !gr, req, {62'h0, go, gr}, 64'h2);
        check(out_data == d, req, out_data, d);
        check(out_is_wr == wr, "R10", {63'h0, out_is_wr}, {63'h0, wr});
        check(err_cnt == m_err, req, err_cnt, m_err);
    endtask

    task automatic expect_reject(input string req);
        bit go, gr;
        wait_outcome(go, gr);
        bump(m_err);
        check(!go && gr, req, {62'h0, go, gr}, 64'h1);
        check(err_cnt == m_err, "R4", err_cnt, m_err);
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            check(retrain_req && !rexmit_req && !out_valid, "R5",
                  {62'h0, retrain_req, rexmit_req}, 64'h2);
        end
        retrain_done = 1'b1;
        @(negedge clk);
        retrain_done = 1'b0;
        bump(m_retry);
        check(rexmit_req && !retrain_req, "R5", {62'h0, rexmit_req, retrain_req}, 64'h2);
        check(retry_cnt == m_retry, "R5", retry_cnt, m_retry);
        @(negedge clk);
        check(!rexmit_req, "R5", {63'h0, rexmit_req}, 64'h0);
    endtask

    task automatic run_burst(input logic [63:0] d, input logic [63:0] dm,
                             input logic [7:0] cm, input logic wr, input logic en,
                             input string req);
        logic [63:0] sd;
        bit bad;
        sd = d ^ dm;
        bad = en && (dm != 0 || cm != 0);
        chk_en = en;
        push_burst(sd, ref_crc(d) ^ cm, wr);
        if (bad) begin
            expect_reject(req);
            push_burst(d, ref_crc(d), wr);
            expect_clean(d, wr, "R2");
        end else begin
            expect_clean(sd, wr, req);
            check(retrain_req == 1'b0, req, {63'h0, retrain_req}, 64'h0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            report();
        end
    end

    initial begin
        rst = 1'b1; chk_en = 1'b1; dat_valid = 1'b0; dat_is_wr = 1'b0;
        edc_valid = 1'b0; retrain_done = 1'b0; cnt_clr = 1'b0;
        dat_word = '0; edc_nib = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(!out_valid && !rexmit_req && !retrain_req, "R1",
              {61'h0, out_valid, rexmit_req, retrain_req}, 64'h0);
        check(err_cnt == 0 && retry_cnt == 0, "R1", {err_cnt, retry_cnt}, 64'h0);
        check(dat_ready && edc_ready, "R1", {62'h0, dat_ready, edc_ready}, 64'h3);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            logic [137:0] e;
            e = VEC[v];
            run_burst(e[137:74], e[73:10], e[9:2], e[1], e[0],
                      e[0] ? "R4" : "R8");
        end

        // R3: judged only after data and both beats
        chk_en = 1'b1;
        push_data(64'hC0FF_EE00_1234_5678, 1'b1);
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            check(!dat_ready && !out_valid && !retrain_req, "R3",
                  {61'h0, dat_ready, out_valid, retrain_req}, 64'h0);
        end
        push_beat(ref_crc(64'hC0FF_EE00_1234_5678) >> 4);
        check(edc_ready && !out_valid, "R3", {62'h0, edc_ready, out_valid}, 64'h2);
        push_beat(ref_crc(64'hC0FF_EE00_1234_5678) & 8'h0F);
        check(!edc_ready && !out_valid, "R3", {62'h0, edc_ready, out_valid}, 64'h0);
        expect_clean(64'hC0FF_EE00_1234_5678, 1'b1, "R3");

        // R8: unchecked mode, bad CRC, counters unchanged
        run_burst(64'h0F0F_0F0F_0F0F_0F0F, 64'h3, 8'h00, 1'b0, 1'b0, "R8");
        check(retry_cnt == m_retry, "R8", retry_cnt, m_retry);

        // R6: every single-bit flip and adjacent double flips
        for (int i = 0; i < 64; i++) begin
            logic [63:0] m1, m2;
            m1 = 64'h1 << i;
            m2 = m1 | (64'h1 << ((i + 1) % 64));
            run_burst(64'hA5C3_96F0_1E2D_3B4C ^ {i[31:0], 32'h0}, m1, 8'h00, i[0], 1'b1, "R6");
            run_burst(64'h6B1E_0C77_D2A9_4F35, m2, 8'h00, i[1], 1'b1, "R6");
        end
        for (int b = 0; b < 8; b++)
            run_burst(64'h2222_3333_4444_5555, 64'h0, 8'h1 << b, 1'b0, 1'b1, "R6");

        // R7: same corrupt burst rejected many times, then clean one released
        chk_en = 1'b1;
        for (int k = 0; k < 20; k++) begin
            push_burst(64'hBAD0_BAD0_BAD0_BAD0, ref_crc(64'hBAD0_BAD0_BAD0_BAD0) ^ 8'h40, 1'b1);
            expect_reject("R7");
        end
        push_burst(64'hBAD0_BAD0_BAD0_BAD0, ref_crc(64'hBAD0_BAD0_BAD0_BAD0), 1'b1);
        expect_clean(64'hBAD0_BAD0_BAD0_BAD0, 1'b1, "R7");

        // R9: saturation and clear
        check(err_cnt == CNT_MAX, "R9", err_cnt, CNT_MAX);
        check(retry_cnt == CNT_MAX, "R9", retry_cnt, CNT_MAX);
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
        m_err = 0; m_retry = 0;
        check(err_cnt == 0 && retry_cnt == 0, "R9", {err_cnt, retry_cnt}, 64'h0);
        run_burst(64'h1111_2222_3333_4444, 64'h0, 8'h08, 1'b0, 1'b1, "R9");
        check(err_cnt == 1 && retry_cnt == 1, "R9", {err_cnt, retry_cnt}, 64'h11);

        finished = 1;
        report();
    end

endmodule